// File: doc/BRIEF.md
# Toggle-Handshake Serial Data Mailbox

This block links a cyclically scanned controller image to a byte-wide serial engine. Each scan, the controller can hand over up to three characters for transmission and collect up to three received characters. Ownership of each batch is signalled with toggle bits: a direction has work pending while its request bit and its acknowledge bit differ, and the batch is complete once they match again. The transmit and receive directions run independently of each other.

Inside, a transmit FIFO drains to the serial transmitter over a valid/ready byte interface. A receive FIFO is filled from the serial receiver, and batches of up to three characters are taken from it and presented to the controller. An initialization request overrides all other activity. While it is set, both directions stop at once, both FIFOs are emptied, and a configuration load is started with a start pulse that ends with a done pulse. The acknowledge is raised after the load completes and is withdrawn once the request is cleared. At that point both directions resume with their toggle pairs equal.

Top module: `toggle_mailbox`

## Requirements
- R1: After reset, `status_o` is 0, `in_data_o` is 0, `tx_valid_o` is 0 and `cfg_start_o` is 0.
- R2: `status_o` bit 7 is always 0. Bits 6..4 hold the received count, bit 3 is receive-buffer full, bit 2 is initialization acknowledge, bit 1 is receive request and bit 0 is transmit acknowledge.
- R3: `ctrl_i` bit 0 is transmit request. When it differs from `status_o` bit 0 and there is room, the first N bytes of `out_data_i` (byte k at bits 8k+7..8k) go into the transmit FIFO in order, and bit 0 takes the request value on the next edge. N is `ctrl_i` bits 6..4.
- R4: An output count above 3 is treated as 3. A count of 0 is acknowledged without queuing anything.
- R5: If the transmit FIFO (16 entries) has fewer free places than N, at the edge where the request is evaluated, the acknowledge is held back and nothing is queued until space exists.
- R6: `tx_valid_o` is high whenever the transmit FIFO is non-empty and no initialization is active. `tx_data_o` shows the oldest character, which is removed on a clock edge where `tx_valid_o` and `tx_ready_i` are both high.
- R7: When `status_o` bit 1 equals `ctrl_i` bit 1 (receive acknowledge) and the receive FIFO is non-empty, the block presents min(fill,3) characters on `in_data_o` (byte k at bits 8k+7..8k, unused bytes zero). It writes that count to bits 6..4 and inverts bit 1, all on the same edge.
- R8: While bit 1 differs from `ctrl_i` bit 1, `in_data_o` and the count stay unchanged.
- R9: Status bit 3 is high while the receive FIFO holds 16 characters. A character offered on `rx_valid_i` while it is full is discarded.
- R10: A transmit acknowledge and a receive presentation can take place on the same edge.
- R11: While `ctrl_i` bit 2 is 1 or an initialization is in progress, both FIFOs are emptied, `tx_valid_o` and `rx_ready_o` are 0, and the toggle outputs track the controller's bits. `cfg_start_o` pulses for one cycle in the first cycle the request is seen.
- R12: Status bit 2 rises on the edge after `cfg_done_i` is seen. It falls on the edge after the request bit reads 0. Transfers resume after that with no transfer pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Controller control byte |
| out_data_i | input | 24 | Three outgoing characters |
| status_o | output | 8 | Status byte to controller |
| in_data_o | output | 24 | Three presented received characters |
| tx_data_o | output | 8 | Character to serial transmitter |
| tx_valid_o | output | 1 | Transmit character valid |
| tx_ready_i | input | 1 | Serial transmitter accepts character |
| rx_data_i | input | 8 | Character from serial receiver |
| rx_valid_i | input | 1 | Received character valid |
| rx_ready_o | output | 1 | Block accepts received characters |
| cfg_start_o | output | 1 | Configuration load start pulse |
| cfg_done_i | input | 1 | Configuration load complete pulse |

## Verification
Transmit batches are sent with counts of 1, 3, 0 and 7, which separates correct clamping and skipping from off-by-one lane selection. A run of full batches with the transmitter stalled drives the FIFO to within one place of full, so the test shows whether a partial batch is refused or squeezed in. On the receive side, a single character, a burst of five and a burst of twenty without acknowledgement show the split into batches, the holding of a pending batch, and the dropping of characters once full. A combined toggle of both directions, and an initialization raised during traffic, show that the two sides are independent and that the request takes priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned LANES    = 3;
  localparam int unsigned CHAR_W   = 8;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned CTL_TR   = 0;
  localparam int unsigned CTL_RA   = 1;
  localparam int unsigned CTL_IR   = 2;
  localparam int unsigned CTL_CNT  = 4;
  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [LANES-1:0][CHAR_W-1:0] lanes_t;
  typedef enum logic [1:0] {INIT_IDLE, INIT_LOAD, INIT_ACK} init_state_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1,
  localparam int unsigned NW = $clog2(LANES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [NW-1:0] wr_num_i,
  input  lanes_t        wr_data_i,
  input  logic [NW-1:0] rd_num_i,
  output lanes_t        rd_data_o,
  output logic [CW-1:0] count_o
);
  char_t [DEPTH-1:0] mem_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      for (int k = 0; k < int'(LANES); k++) begin
        if (k < int'(wr_num_i)) mem_q[wr_ptr_q + AW'(k)] <= wr_data_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + AW'(wr_num_i);
      rd_ptr_q <= rd_ptr_q + AW'(rd_num_i);
      cnt_q    <= cnt_q + CW'(wr_num_i) - CW'(rd_num_i);
    end
  end

  for (genvar g = 0; g < int'(LANES); g++) begin : g_peek
    assign rd_data_o[g] = mem_q[rd_ptr_q + AW'(g)];
  end

  assign count_o = cnt_q;

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (int'(cnt_q) + int'(wr_num_i) <= int'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (int'(rd_num_i) <= int'(cnt_q)));
endmodule

// File: rtl/mbx_tx_port.sv
module mbx_tx_port
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1,
  localparam int unsigned NW = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             tr_i,
  input  logic [CNT_W-1:0] cnt_req_i,
  input  lanes_t           data_i,
  input  logic             tx_ready_i,
  output logic             ta_o,
  output char_t            tx_data_o,
  output logic             tx_valid_o
);
  logic ta_q;
  logic [NW-1:0] num, wr_num, rd_num;
  logic [CW-1:0] count;
  lanes_t peek;
  logic room, take;

  // clamp requested count to the lane count
  assign num    = (int'(cnt_req_i) > int'(LANES)) ? NW'(LANES) : NW'(cnt_req_i);
  assign room   = (int'(DEPTH) - int'(count)) >= int'(num);
  assign take   = !busy_i && (tr_i != ta_q) && room;
  assign wr_num = take ? num : '0;
  assign tx_valid_o = (count != '0) && !busy_i;
  assign rd_num = (tx_valid_o && tx_ready_i) ? NW'(1) : '0;
  assign tx_data_o  = peek[0];

  mbx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (busy_i),
    .wr_num_i (wr_num),
    .wr_data_i(data_i),
    .rd_num_i (rd_num),
    .rd_data_o(peek),
    .count_o  (count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ta_q <= 1'b0;
    else if (busy_i)    ta_q <= tr_i;
    else if (take)      ta_q <= tr_i;
  end

  assign ta_o = ta_q;

  assert_ack_withheld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && (tr_i != ta_q) && !room) |=> $stable(ta_q));
endmodule

// File: rtl/mbx_rx_port.sv
module mbx_rx_port
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1,
  localparam int unsigned NW = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             ra_i,
  input  char_t            rx_data_i,
  input  logic             rx_valid_i,
  output logic             rx_ready_o,
  output logic             rr_o,
  output logic             full_o,
  output logic [CNT_W-1:0] in_cnt_o,
  output lanes_t           in_data_o
);
  logic rr_q;
  logic [CNT_W-1:0] in_cnt_q;
  lanes_t in_data_q, peek, wr_data;
  logic [NW-1:0] num, wr_num, rd_num;
  logic [CW-1:0] count;
  logic present;

  assign full_o     = (int'(count) == int'(DEPTH));
  assign rx_ready_o = !busy_i;
  assign wr_num     = (rx_valid_i && !busy_i && !full_o) ? NW'(1) : '0;
  assign num        = (int'(count) > int'(LANES)) ? NW'(LANES) : NW'(count);
  assign present    = !busy_i && (rr_q == ra_i) && (count != '0);
  assign rd_num     = present ? num : '0;

  always_comb begin
    wr_data    = '0;
    wr_data[0] = rx_data_i;
  end

  mbx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (busy_i),
    .wr_num_i (wr_num),
    .wr_data_i(wr_data),
    .rd_num_i (rd_num),
    .rd_data_o(peek),
    .count_o  (count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q      <= 1'b0;
      in_cnt_q  <= '0;
      in_data_q <= '0;
    end else if (busy_i) begin
      rr_q      <= ra_i;
      in_cnt_q  <= '0;
      in_data_q <= '0;
    end else if (present) begin
      rr_q     <= ~rr_q;
      in_cnt_q <= CNT_W'(num);
      for (int k = 0; k < int'(LANES); k++)
        in_data_q[k] <= (k < int'(num)) ? peek[k] : '0;
    end
  end

  assign rr_o      = rr_q;
  assign in_cnt_o  = in_cnt_q;
  assign in_data_o = in_data_q;

  assert_batch_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && (rr_q != ra_i)) |=> ($stable(in_data_q) && $stable(in_cnt_q)));
endmodule

// File: rtl/mbx_init_ctl.sv
module mbx_init_ctl
  import mbx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  input  logic cfg_done_i,
  output logic busy_o,
  output logic ia_o,
  output logic cfg_start_o
);
  init_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      INIT_IDLE: if (ir_i)       state_d = INIT_LOAD;
      INIT_LOAD: if (cfg_done_i) state_d = INIT_ACK;
      INIT_ACK:  if (!ir_i)      state_d = INIT_IDLE;
      default:                   state_d = INIT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= INIT_IDLE;
    else         state_q <= state_d;
  end

  // request blocks transfers in the very cycle it appears
  assign busy_o      = ir_i || (state_q != INIT_IDLE);
  assign ia_o        = (state_q == INIT_ACK);
  assign cfg_start_o = (state_q == INIT_IDLE) && ir_i;

  assert_start_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_start_o |=> !cfg_start_o);
  assert_ack_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ia_o && !ir_i) |=> !ia_o);
endmodule

// File: rtl/toggle_mailbox.sv
module toggle_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  ctrl_i,
  input  logic [23:0] out_data_i,
  output logic [7:0]  status_o,
  output logic [23:0] in_data_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  output logic        cfg_start_o,
  input  logic        cfg_done_i
);
  logic busy, ia, ta, rr, full;
  logic [CNT_W-1:0] in_cnt;
  lanes_t out_lanes, in_lanes;

  assign out_lanes = out_data_i;

  mbx_init_ctl u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ir_i       (ctrl_i[CTL_IR]),
    .cfg_done_i (cfg_done_i),
    .busy_o     (busy),
    .ia_o       (ia),
    .cfg_start_o(cfg_start_o)
  );

  mbx_tx_port #(.DEPTH(FIFO_DEPTH)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .tr_i      (ctrl_i[CTL_TR]),
    .cnt_req_i (ctrl_i[CTL_CNT +: CNT_W]),
    .data_i    (out_lanes),
    .tx_ready_i(tx_ready_i),
    .ta_o      (ta),
    .tx_data_o (tx_data_o),
    .tx_valid_o(tx_valid_o)
  );

  mbx_rx_port #(.DEPTH(FIFO_DEPTH)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .ra_i      (ctrl_i[CTL_RA]),
    .rx_data_i (rx_data_i),
    .rx_valid_i(rx_valid_i),
    .rx_ready_o(rx_ready_o),
    .rr_o      (rr),
    .full_o    (full),
    .in_cnt_o  (in_cnt),
    .in_data_o (in_lanes)
  );

  assign status_o  = {1'b0, in_cnt, full, ia, rr, ta};
  assign in_data_o = in_lanes;

  assert_init_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[CTL_IR] |-> (!tx_valid_o && !rx_ready_o));
endmodule

// File: tb/toggle_mailbox_tb_top.sv
module toggle_mailbox_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [7:0]  ctrl, status;
  logic [23:0] out_data, in_data;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, cfg_start, cfg_done;

  toggle_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .out_data_i(out_data),
    .status_o(status), .in_data_o(in_data), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .cfg_start_o(cfg_start),
    .cfg_done_i(cfg_done)
  );

  // controller-side stimulus
  logic tr = 0, ra = 0, ir = 0;
  logic [2:0] ocnt = 0;
  logic [7:0] ob [3];
  assign ctrl     = {1'b0, ocnt, 1'b0, ir, ra, tr};
  assign out_data = {ob[2], ob[1], ob[0]};

  int checks = 0, errors = 0, tx_seen = 0;
  bit finished = 0;

  // reference model
  bit m_ta = 0, m_rr = 0;
  int m_st = 0, m_cnt = 0;
  byte unsigned txq[$], rxq[$];
  byte unsigned m_in[3];

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit busy = ir || (m_st != 0);
    chk("R2", int'(status[7]), 0);
    chk("R3", int'(status[0]), int'(m_ta));
    chk("R8", int'(status[1]), int'(m_rr));
    chk("R12", int'(status[2]), int'(m_st == 2));
    chk("R9", int'(status[3]), int'(rxq.size() == 16));
    chk("R7", int'(status[6:4]), m_cnt);
    for (int k = 0; k < 3; k++) chk("R7", int'(in_data[8*k +: 8]), int'(m_in[k]));
    chk("R6", int'(tx_valid), int'(txq.size() > 0 && !busy));
    if (tx_valid && txq.size() > 0) chk("R6", int'(tx_data), int'(txq[0]));
    chk("R11", int'(rx_ready), int'(!busy));
    chk("R11", int'(cfg_start), int'(m_st == 0 && ir));
  endtask

  task automatic model_update();
    bit busy = ir || (m_st != 0);
    int tsz = txq.size();
    int rsz = rxq.size();
    int n;
    if (busy) begin
      txq.delete(); rxq.delete();
      m_ta = tr; m_rr = ra; m_cnt = 0;
      for (int k = 0; k < 3; k++) m_in[k] = 0;
    end else begin
      if (tsz > 0 && tx_ready) void'(txq.pop_front());
      if (tr != m_ta) begin
        n = (ocnt > 3) ? 3 : int'(ocnt);
        if (16 - tsz >= n) begin
          for (int k = 0; k < n; k++) txq.push_back(ob[k]);
          m_ta = tr;
        end
      end
      if (m_rr == ra && rsz > 0) begin
        n = (rsz > 3) ? 3 : rsz;
        for (int k = 0; k < 3; k++) m_in[k] = (k < n) ? rxq.pop_front() : 8'h00;
        m_cnt = n;
        m_rr = !m_rr;
      end
      if (rx_valid && rsz < 16) rxq.push_back(rx_data);
    end
    if (m_st == 0 && ir) m_st = 1;
    else if (m_st == 1 && cfg_done) m_st = 2;
    else if (m_st == 2 && !ir) m_st = 0;
  endtask

  task automatic step();
    #1 compare();
    if (tx_valid && tx_ready) tx_seen++;
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send(logic [2:0] c, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    ob[0] = b0; ob[1] = b1; ob[2] = b2; ocnt = c; tr = ~tr;
  endtask

  task automatic rx_push(logic [7:0] d);
    rx_valid = 1; rx_data = d; step(); rx_valid = 0;
  endtask

  task automatic ack_all();
    for (int i = 0; i < 12; i++) begin
      if (status[1] != ra) ra = ~ra;
      steps(2);
    end
  endtask

  initial begin
    int s0;
    rst_n = 0; tx_ready = 0; rx_valid = 0; rx_data = 0; cfg_done = 0;
    ob[0] = 0; ob[1] = 0; ob[2] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk("R1", int'(status), 0);
    chk("R1", int'(in_data), 0);
    chk("R1", int'(tx_valid), 0);
    chk("R1", int'(cfg_start), 0);
    @(negedge clk);

    // single char, then three chars
    tx_ready = 1;
    send(3'd1, 8'h41, 8'h00, 8'h00); steps(3);
    chk("R3", int'(status[0]), int'(tr));
    send(3'd3, 8'h51, 8'h52, 8'h53); steps(6);
    // R4 zero count: acknowledged, nothing queued
    s0 = tx_seen;
    send(3'd0, 8'hEE, 8'hEE, 8'hEE); steps(4);
    chk("R4", tx_seen - s0, 0);
    chk("R4", int'(status[0]), int'(tr));
    // R4 clamp of 7 to 3
    tx_ready = 0; s0 = tx_seen;
    send(3'd7, 8'h61, 8'h62, 8'h63); steps(2);
    tx_ready = 1; steps(6);
    chk("R4", tx_seen - s0, 3);

    // R5 fill to 15 with transmitter stalled, then a batch of 2 is refused
    tx_ready = 0;
    for (int b = 0; b < 5; b++) begin
      send(3'd3, 8'(8'h10 + 3*b), 8'(8'h11 + 3*b), 8'(8'h12 + 3*b)); steps(2);
    end
    send(3'd2, 8'hA0, 8'hA1, 8'h00); steps(3);
    chk("R5", int'(status[0] != tr), 1);
    tx_ready = 1; step(); tx_ready = 0; steps(2);
    chk("R5", int'(status[0]), int'(tr));
    tx_ready = 1; steps(20);

    // receive: single, burst of five
    rx_push(8'h31); steps(2);
    chk("R7", int'(status[6:4]), 1);
    ra = ~ra; steps(2);
    for (int i = 0; i < 5; i++) rx_push(8'(8'h70 + i));
    steps(2);
    ack_all();

    // overflow with no acknowledgement
    for (int i = 0; i < 20; i++) rx_push(8'(8'h80 + i));
    step();
    chk("R9", int'(status[3]), 1);
    ack_all();

    // R10 simultaneous: one pending batch plus a waiting char
    rx_push(8'hC1); steps(2);
    rx_push(8'hC2); steps(1);
    send(3'd2, 8'hD1, 8'hD2, 8'h00); ra = ~ra; step();
    chk("R10", int'(status[0] == tr && status[1] != ra), 1);
    ack_all(); steps(4);

    // initialization during traffic
    tx_ready = 0;
    send(3'd3, 8'hE1, 8'hE2, 8'hE3); steps(2);
    rx_push(8'hF1); rx_push(8'hF2); steps(2);
    ir = 1; tr = ~tr; step();
    chk("R11", int'(tx_valid), 0);
    chk("R11", int'(rx_ready), 0);
    tx_ready = 1; rx_valid = 1; rx_data = 8'h99; steps(3); rx_valid = 0;
    cfg_done = 1; step(); cfg_done = 0; step();
    chk("R12", int'(status[2]), 1);
    ir = 0; steps(2);
    chk("R12", int'(status[2]), 0);
    chk("R12", int'(status[0]), int'(tr));
    chk("R12", int'(status[1]), int'(ra));
    send(3'd1, 8'h5A, 8'h00, 8'h00); steps(4);
    rx_push(8'hA5); steps(2);
    ack_all();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule